// File: doc/BRIEF.md
# Full-Bridge Commutation Controller

This block drives the four gate enables of an H-bridge (high-left, high-right, low-left, low-right) from one system clock. Supply supervision, oscillator timing and level shifting sit outside it and arrive as digital flags and clocks. While the supply is not yet good, the block holds the bridge in a charging pattern with both low-side switches on. Once the supply is released, it alternates the bridge between its two diagonal conduction states. Every change of diagonal passes through a fixed all-off interval.

Two switching schemes are available. With the divider in use, each falling edge of the selected source flips the diagonal. The source is either the internal oscillator clock or the external drive input. This halves the frequency and gives an exact 50% duty factor, and the bridge always starts from one preferred diagonal. With the divider bypassed, the diagonal follows the level of the external drive input. A disable input forces every switch off. It overrides every other state, including the charging pattern.

Top module: `hbridge_commutator`

## Requirements
- R1: The gates only ever show one of four patterns, written {hl,hr,ll,lr}: 0000 (all off), 0011 (charging), 1001 (diagonal A: high-left with low-right) or 0110 (diagonal B: high-right with low-left). A switch and the other switch on its own leg are never on together.
- R2: In reset, and while `supply_release` has not yet been seen high since reset or since the last supply drop, the gates show 0011.
- R3: While `bridge_off` is high (after one register stage), the gates show 0000. This holds in the charging state as well.
- R4: With the divider in use (`div_bypass` = 0), the first diagonal after leaving the charging state or the disabled state is always A.
- R5: With the divider in use and `osc_sel` = 0, each falling edge of `osc_int` moves the bridge to the other diagonal. N falling edges therefore give N commutations and N/2 entries into diagonal A.
- R6: With `osc_sel` = 0, edges on `ext_drive` cause no commutation. With `osc_sel` = 1, edges on `osc_int` cause none, and each falling edge of `ext_drive` commutes.
- R7: With `div_bypass` = 1, the bridge shows diagonal A while the synchronized `ext_drive` is high and diagonal B while it is low.
- R8: A high `supply_reset` sends the block back to the charging state on the next clock. The charging state has priority over release.
- R9: Every change of diagonal is preceded by exactly DEAD_CYCLES clocks of 0000. Diagonal A never directly follows B, and B never directly follows A.
- R10: A selected falling edge that arrives during a dead interval is kept. After the interval ends, the bridge conducts for one clock and then commutes again.
- R11: When `bridge_off` falls, the first conduction appears DEAD_CYCLES + 2 clocks later: one clock for the disable register, one to leave the off state, and then the dead interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_release | input | 1 | High when the supply is above the release level |
| supply_reset | input | 1 | High when the supply is below the reset level |
| bridge_off | input | 1 | Forces all four gates off |
| div_bypass | input | 1 | 1 = bypass the divide-by-two and follow `ext_drive` |
| osc_sel | input | 1 | Divider source: 0 = `osc_int`, 1 = `ext_drive` |
| osc_int | input | 1 | Internal oscillator clock (asynchronous) |
| ext_drive | input | 1 | External drive signal (asynchronous) |
| gate_hl | output | 1 | High-left switch enable |
| gate_hr | output | 1 | High-right switch enable |
| gate_ll | output | 1 | Low-left switch enable |
| gate_lr | output | 1 | Low-right switch enable |

## Verification
The assertions watch, on every clock, the rules that can be read from a single state change:
- no same-leg overlap and no direct diagonal swap;
- the charging and all-off patterns;
- the fall back to charging on a supply drop;
- the exact length of each dead interval, counted by a checker counter;
- diagonal A as the first diagonal in divider mode.

Only the bench's scenarios can show the following:
- that the commutation count matches the number of source edges, so the frequency is halved;
- that the unselected source is ignored;
- that level following works in bypass mode;
- that an edge falling inside a dead interval is kept and acted on;
- how long the bridge takes to restart after a disable.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_OFF   = 2'd1,
    ST_DEAD  = 2'd2,
    ST_ON    = 2'd3
  } hb_state_t;

  typedef enum logic {
    DIAG_A = 1'b0,
    DIAG_B = 1'b1
  } hb_diag_t;

  typedef struct packed {
    logic hl;
    logic hr;
    logic ll;
    logic lr;
  } hb_gates_t;

  // Follow mode: a high drive level selects diagonal A.
  function automatic hb_diag_t diag_from_level(input logic lvl);
    return lvl ? DIAG_A : DIAG_B;
  endfunction

  function automatic hb_diag_t diag_flip(input hb_diag_t d);
    return (d == DIAG_A) ? DIAG_B : DIAG_A;
  endfunction

  // Gate decode: the disable wins, then the charging pattern, then the diagonal.
  function automatic hb_gates_t gate_pattern(input hb_state_t st, input hb_diag_t d,
                                             input logic off);
    hb_gates_t g;
    g = '0;
    if (!off) begin
      if (st == ST_START) begin
        g.ll = 1'b1;
        g.lr = 1'b1;
      end else if (st == ST_ON) begin
        if (d == DIAG_A) begin
          g.hl = 1'b1;
          g.lr = 1'b1;
        end else begin
          g.hr = 1'b1;
          g.ll = 1'b1;
        end
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/hb_edge_sync.sv
module hb_edge_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] fall
);

  localparam int LAST = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], din[i]};
        prev  <= chain[LAST];
      end
    end

    assign level[i] = chain[LAST];
    assign fall[i]  = prev & ~chain[LAST];
  end

endmodule

// File: rtl/hb_commutation_fsm.sv
module hb_commutation_fsm
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      supply_release,
  input  logic      supply_reset,
  input  logic      off_req,
  input  logic      div_en,
  input  logic      edge_evt,
  input  hb_diag_t  level_diag,
  output hb_state_t state,
  output hb_diag_t  diag,
  output logic      fresh
);

  localparam int CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEAD_CYCLES - 1);

  logic [CW-1:0] cnt;
  hb_diag_t      nxt;
  logic          pend;
  logic          dead_done;
  logic          div_edge;

  assign dead_done = (state == ST_DEAD) && (cnt == CNT_LAST);
  assign div_edge  = div_en && edge_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || supply_reset) begin
      state <= ST_START;
      diag  <= DIAG_A;
      nxt   <= DIAG_A;
      cnt   <= '0;
      pend  <= 1'b0;
      fresh <= 1'b1;
    end else begin
      unique case (state)
        ST_START, ST_OFF: begin
          if ((state == ST_OFF || supply_release) && !off_req) begin
            state <= ST_DEAD;
            cnt   <= '0;
            nxt   <= DIAG_A;
            pend  <= 1'b0;
            fresh <= 1'b1;
          end else if (state == ST_START && supply_release) begin
            state <= ST_OFF;
          end
        end
        ST_DEAD: begin
          if (off_req) begin
            state <= ST_OFF;
            pend  <= 1'b0;
          end else begin
            if (div_edge) pend <= 1'b1;
            if (dead_done) begin
              state <= ST_ON;
              diag  <= div_en ? nxt : level_diag;
              fresh <= 1'b0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_ON: begin
          if (off_req) begin
            state <= ST_OFF;
            pend  <= 1'b0;
          end else if (div_en ? (div_edge || pend) : (level_diag != diag)) begin
            state <= ST_DEAD;
            cnt   <= '0;
            nxt   <= diag_flip(diag);
            pend  <= 1'b0;
          end
        end
        default: state <= ST_START;
      endcase
    end
  end

endmodule

// File: rtl/hb_gate_decode.sv
module hb_gate_decode
  import hb_pkg::*;
(
  input  hb_state_t state,
  input  hb_diag_t  diag,
  input  logic      off_req,
  output logic      hl,
  output logic      hr,
  output logic      ll,
  output logic      lr
);

  hb_gates_t g;

  assign g  = gate_pattern(state, diag, off_req);
  assign hl = g.hl;
  assign hr = g.hr;
  assign ll = g.ll;
  assign lr = g.lr;

endmodule

// File: rtl/hbridge_commutator.sv
module hbridge_commutator
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_release,
  input  logic supply_reset,
  input  logic bridge_off,
  input  logic div_bypass,
  input  logic osc_sel,
  input  logic osc_int,
  input  logic ext_drive,
  output logic gate_hl,
  output logic gate_hr,
  output logic gate_ll,
  output logic gate_lr
);

  localparam int SRC_INT = 0;
  localparam int SRC_EXT = 1;
  localparam int N_SRC   = 2;

  logic             dis_q;
  logic [N_SRC-1:0] src_level;
  logic [N_SRC-1:0] src_fall;
  logic             sel_fall;
  logic             div_en;
  hb_diag_t         level_diag;
  hb_state_t        fsm_state;
  hb_diag_t         fsm_diag;
  logic             fsm_fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) dis_q <= 1'b0;
    else        dis_q <= bridge_off;
  end

  hb_edge_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ext_drive, osc_int}),
    .level (src_level),
    .fall  (src_fall)
  );

  assign sel_fall   = osc_sel ? src_fall[SRC_EXT] : src_fall[SRC_INT];
  assign div_en     = ~div_bypass;
  assign level_diag = diag_from_level(src_level[SRC_EXT]);

  hb_commutation_fsm #(.DEAD_CYCLES(DEAD_CYCLES)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_release (supply_release),
    .supply_reset   (supply_reset),
    .off_req        (dis_q),
    .div_en         (div_en),
    .edge_evt       (sel_fall),
    .level_diag     (level_diag),
    .state          (fsm_state),
    .diag           (fsm_diag),
    .fresh          (fsm_fresh)
  );

  hb_gate_decode u_dec (
    .state   (fsm_state),
    .diag    (fsm_diag),
    .off_req (dis_q),
    .hl      (gate_hl),
    .hr      (gate_hr),
    .ll      (gate_ll),
    .lr      (gate_lr)
  );

endmodule

// File: rtl/hbridge_commutator_checker.sv
module hbridge_commutator_checker
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 2
) (
  input logic      clk,
  input logic      rst_n,
  input logic      supply_reset,
  input logic      dis_q,
  input logic      div_en,
  input hb_state_t fsm_state,
  input logic      fsm_fresh,
  input logic      gate_hl,
  input logic      gate_hr,
  input logic      gate_ll,
  input logic      gate_lr
);

  localparam int RW = $clog2(DEAD_CYCLES + 2) + 1;

  logic [RW-1:0] dead_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                    dead_run <= '0;
    else if (fsm_state == ST_DEAD) dead_run <= dead_run + RW'(1);
    else                           dead_run <= '0;
  end

  p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hl && gate_ll) && !(gate_hr && gate_lr) && ($countones({gate_hl, gate_hr, gate_ll, gate_lr}) <= 2));

  p_charging_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_START && !dis_q) |-> (!gate_hl && !gate_hr && gate_ll && gate_lr));

  p_off_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !(gate_hl || gate_hr || gate_ll || gate_lr));

  p_first_diag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_ON && $past(fsm_state) == ST_DEAD && $past(fsm_fresh) && $past(div_en))
      |-> (gate_hl && gate_lr));

  p_supply_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_reset |=> (fsm_state == ST_START));

  p_no_swap_ab_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hl && gate_lr) |=> !(gate_hr && gate_ll));

  p_no_swap_ba_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hr && gate_ll) |=> !(gate_hl && gate_lr));

  p_dead_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_ON && $past(fsm_state) == ST_DEAD) |-> (dead_run == RW'(DEAD_CYCLES)));

endmodule

bind hbridge_commutator hbridge_commutator_checker #(.DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_reset (supply_reset),
  .dis_q        (dis_q),
  .div_en       (div_en),
  .fsm_state    (fsm_state),
  .fsm_fresh    (fsm_fresh),
  .gate_hl      (gate_hl),
  .gate_hr      (gate_hr),
  .gate_ll      (gate_ll),
  .gate_lr      (gate_lr)
);

// File: tb/hbridge_commutator_test.sv
module hbridge_commutator_test;

  localparam int DT = 2;
  localparam logic [3:0] PAT_OFF = 4'b0000;
  localparam logic [3:0] PAT_CHG = 4'b0011;
  localparam logic [3:0] PAT_A   = 4'b1001;
  localparam logic [3:0] PAT_B   = 4'b0110;

  // {release, supply_reset, bridge_off, div_bypass, osc_sel, ext_drive, expected {hl,hr,ll,lr}}
  localparam int NSTEP = 10;
  localparam logic [9:0] STEPS [NSTEP] = '{
    {6'b000000, PAT_CHG},  // R2 charging before release
    {6'b001000, PAT_OFF},  // R3 disable overrides charging
    {6'b100000, PAT_A},    // R4 first diagonal after release
    {6'b100100, PAT_B},    // R7 follow low level
    {6'b100101, PAT_A},    // R7 follow high level
    {6'b100100, PAT_B},    // R7 follow low again
    {6'b101100, PAT_OFF},  // R3 disable in run
    {6'b100000, PAT_A},    // R4 first diagonal after disable
    {6'b110000, PAT_CHG},  // R8 supply drop
    {6'b100000, PAT_A}     // R4 first diagonal after supply return
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_release = 1'b0;
  logic supply_reset = 1'b0;
  logic bridge_off = 1'b0;
  logic div_bypass = 1'b0;
  logic osc_sel = 1'b0;
  logic osc_int = 1'b1;
  logic ext_drive = 1'b0;
  logic gate_hl, gate_hr, gate_ll, gate_lr;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int off_len = 0;
  int comm = 0;
  int a_entries = 0;
  logic [3:0] last_pat = 4'b0000;

  always #10 clk = ~clk;

  hbridge_commutator #(.DEAD_CYCLES(DT)) uut (
    .clk(clk), .rst_n(rst_n), .supply_release(supply_release), .supply_reset(supply_reset),
    .bridge_off(bridge_off), .div_bypass(div_bypass), .osc_sel(osc_sel), .osc_int(osc_int),
    .ext_drive(ext_drive), .gate_hl(gate_hl), .gate_hr(gate_hr), .gate_ll(gate_ll), .gate_lr(gate_lr)
  );

  function automatic logic [3:0] pats();
    return {gate_hl, gate_hr, gate_ll, gate_lr};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pat(input string req, input logic [3:0] exp);
    checks++;
    if (pats() !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, pats(), exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 legality and R9 dead length, watched at every falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (!(pats() inside {PAT_OFF, PAT_CHG, PAT_A, PAT_B})) begin
        errors++;
        $display("FAIL R1: actual %b expected a legal pattern", pats());
      end
      if (mon_on) begin
        if (pats() == PAT_OFF) begin
          off_len++;
        end else begin
          if (off_len > 0) begin
            chk("R9 dead length", off_len, DT);
            if (pats() != last_pat) comm++;
            if (pats() == PAT_A && last_pat != PAT_A) a_entries++;
          end
          off_len = 0;
          last_pat = pats();
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 reset state
    wait_neg(3);
    chk_pat("R2 in reset", PAT_CHG);
    rst_n = 1'b1;
    wait_neg(2);

    for (int i = 0; i < NSTEP; i++) begin
      {supply_release, supply_reset, bridge_off, div_bypass, osc_sel, ext_drive} = STEPS[i][9:4];
      wait_neg(12);
      chk_pat($sformatf("table step %0d (R2/R3/R4/R7/R8)", i), STEPS[i][3:0]);
    end

    // R5: eight falling edges of the internal oscillator, divider in use
    last_pat = pats(); comm = 0; a_entries = 0; off_len = 0; mon_on = 1'b1;
    for (int k = 0; k < 8; k++) begin
      osc_int = 1'b0; wait_neg(4);
      osc_int = 1'b1; wait_neg(4);
    end
    wait_neg(10);
    chk("R5 commutations", comm, 8);
    chk("R5 entries into A", a_entries, 4);
    chk_pat("R5 final diagonal", PAT_A);

    // R6: external edges ignored while the internal source is selected
    comm = 0;
    for (int k = 0; k < 3; k++) begin
      ext_drive = 1'b1; wait_neg(5);
      ext_drive = 1'b0; wait_neg(5);
    end
    chk("R6 unselected external ignored", comm, 0);
    chk_pat("R6 held diagonal", PAT_A);
    osc_sel = 1'b1;
    wait_neg(4);
    for (int k = 0; k < 3; k++) begin
      osc_int = 1'b0; wait_neg(5);
      osc_int = 1'b1; wait_neg(5);
    end
    chk("R6 unselected internal ignored", comm, 0);
    for (int k = 0; k < 3; k++) begin
      ext_drive = 1'b1; wait_neg(6);
      ext_drive = 1'b0; wait_neg(6);
    end
    wait_neg(6);
    chk("R6 external commutations", comm, 3);
    chk_pat("R6 odd count ends on B", PAT_B);

    // R10: two falling edges two clocks apart, the second inside the dead time
    comm = 0;
    ext_drive = 1'b1; wait_neg(6);
    ext_drive = 1'b0; wait_neg(1);
    ext_drive = 1'b1; wait_neg(1);
    ext_drive = 1'b0; wait_neg(14);
    chk("R10 pending edge kept", comm, 2);
    chk_pat("R10 back on B", PAT_B);
    mon_on = 1'b0;

    // R11: restart latency after disable
    bridge_off = 1'b1;
    wait_neg(6);
    chk_pat("R3 disable while running", PAT_OFF);
    bridge_off = 1'b0;
    begin
      int n;
      n = 0;
      while (pats() == PAT_OFF && n < 20) begin
        @(posedge clk); #1;
        n++;
      end
      chk("R11 restart latency", n, DT + 2);
    end
    wait_neg(1);
    chk_pat("R11 restart on A", PAT_A);

    // R8: supply drop wins over release on the next clock
    supply_reset = 1'b1;
    @(posedge clk); #1;
    chk_pat("R8 one clock after drop", PAT_CHG);
    supply_reset = 1'b0;
    wait_neg(10);
    chk_pat("R8 recovered to A", PAT_A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule